// File: doc/BRIEF.md
# Serial ADC capture controller

This block is the host-side master for a 12-bit successive-approximation converter that has a three-wire serial link: a convert line driven by the host, a serial clock driven by the host, and a serial data line returned by the converter. From a fast system clock it makes the convert pulse and a gated serial clock, samples the returned bits, and hands the assembled word to the host with a one-cycle valid strobe.

The host asks for a frame with a one-cycle start pulse while the block reports it is ready, and picks one of four modes. Normal mode reads the word most significant bit first and leaves the converter acquiring. Power-saving mode keeps convert low through the end of the frame so the converter sleeps until the next frame. Replay mode makes the converter send the word a second time, least significant bit first, and captures that copy. Short mode stops the conversion after N bits, which gives a quicker, coarser result. All timing limits of the link are given in nanoseconds and turned into system-clock counts when the block is elaborated.

Top module: `adc_capture_ctrl`

## Requirements
- R1: After reset, convert and serial clock are low, ready is high, done is low, and result and nvalid are zero.
- R2: Within a frame every serial clock high phase and every rise-to-rise period are exact: the half period is HALF_DIV system cycles, raised to at least ceil(125 / (2*SYS_NS)) and ceil(50 / SYS_NS) and lowered to at most floor(5000 / (2*SYS_NS)).
- R3: Convert is high for more than ceil(ACQ_NS / SYS_NS) cycles before the fall that starts a conversion, and the first clock of the frame rises exactly one half period after that fall. Acquisition time counts from the moment convert rose, so a frame that follows a normal-mode frame reaches its hold sooner than one that follows a power-saving frame.
- R4: Convert never changes while the serial clock is high, except in the cycle in which the clock rises.
- R5: Mode 2'b00 (normal): 13 clocks are sent. The bits sampled at the rising edges of clocks 2 to 13 give result[11] down to result[0]. Convert rises with clock 12 and stays high after done.
- R6: Mode 2'b10 (power saving): 13 clocks are sent and the result is assembled as in normal mode. Convert stays low for the whole frame and after done.
- R7: Mode 2'b01 (replay): 24 clocks are sent. Convert is high only during clock 12. result[i] is the bit sampled at the rise of clock 13+i.
- R8: Mode 2'b11 (short): N is nbits limited to the range 1 to 10 (0 gives 1, values above 10 give 10). N+2 clocks are sent. Convert is high only during clock N+1. The bits from clocks 2 to N+1 fill result[11] downward, the other bits are zero, and nvalid equals N.
- R9: done is a one-cycle pulse. result and nvalid change only with done and keep their values until the next done. nvalid is 12 in every mode except short mode.
- R10: A start pulse while ready is low is ignored. The frame in progress keeps its mode, and no extra frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a frame (taken only while ready) |
| mode | input | 2 | 00 normal, 01 replay, 10 power saving, 11 short |
| nbits | input | 4 | Bit count for short mode |
| ready | output | 1 | Idle and able to accept start |
| done | output | 1 | One-cycle strobe: result is valid |
| result | output | 12 | Assembled conversion word, MSB-aligned |
| nvalid | output | 4 | Number of valid bits in result |
| conv_o | output | 1 | Convert line to the converter |
| sclk_o | output | 1 | Gated serial clock to the converter |
| sdata_i | input | 1 | Serial data from the converter |

## Verification
The bench models the converter. It serves a chosen word in step with the clocks it counts, and after convert falls in short mode it drives junk ones, so a word that is not zero-filled shows up at once. The words all-ones, all-zeros, one-hot ends and random values tell a wrong bit order, a bit that sticks or an off-by-one shift from correct assembly. The short lengths 0, 1, 10 and 15 check both ends of the length limit. A normal frame followed by a normal frame, compared with a frame that follows a power-saving frame, shows whether acquisition is counted from the rise of convert. A start issued in the middle of a frame with a different mode shows whether a busy request leaks into the frame.

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl #(
  parameter int SYS_NS   = 4,
  parameter int HALF_DIV = 10,
  parameter int ACQ_NS   = 350
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  mode,
  input  logic [3:0]  nbits,
  output logic        ready,
  output logic        done,
  output logic [11:0] result,
  output logic [3:0]  nvalid,
  output logic        conv_o,
  output logic        sclk_o,
  input  logic        sdata_i
);
  localparam int W         = 12;
  localparam int HALF_LO_A = (125 + 2*SYS_NS - 1) / (2*SYS_NS);
  localparam int HALF_LO_B = (50 + SYS_NS - 1) / SYS_NS;
  localparam int HALF_MIN  = HALF_LO_A > HALF_LO_B ? HALF_LO_A : HALF_LO_B;
  localparam int HALF_MAX  = 5000 / (2*SYS_NS);
  localparam int HALF_CYC  = HALF_DIV < HALF_MIN ? HALF_MIN :
                             (HALF_DIV > HALF_MAX ? HALF_MAX : HALF_DIV);
  localparam int ACQ_CYC   = (ACQ_NS + SYS_NS - 1) / SYS_NS;
  localparam int TW        = $clog2(HALF_MAX + 1);
  localparam int AW        = $clog2(ACQ_CYC + 1);
  localparam logic [1:0] M_NORM = 2'd0, M_LSB = 2'd1, M_SHORT = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_ACQ, S_GAP, S_HI, S_LO} state_t;

  state_t        state;
  logic [TW-1:0] tick;
  logic [4:0]    k, kn, k_last;
  logic [1:0]    md;
  logic [3:0]    nn, n_req;
  logic [W-1:0]  sr;
  logic [AW-1:0] acq;
  logic          half_end, conv_at_rise, take;

  assign ready    = state == S_IDLE;
  assign half_end = tick == TW'(HALF_CYC - 1);
  assign n_req    = nbits == 4'd0 ? 4'd1 : (nbits > 4'd10 ? 4'd10 : nbits);
  assign kn       = state == S_GAP ? 5'd1 : k + 5'd1;
  assign k_last   = md == M_LSB ? 5'd24 : (md == M_SHORT ? {1'b0, nn} + 5'd2 : 5'd13);
  assign take     = kn >= 5'd2 && (md != M_SHORT || kn <= {1'b0, nn} + 5'd1);

  always_comb begin
    conv_at_rise = conv_o;
    case (md)
      M_NORM:  if (kn == 5'd12) conv_at_rise = 1'b1;
      M_LSB:   if (kn == 5'd12) conv_at_rise = 1'b1;
               else if (kn == 5'd13) conv_at_rise = 1'b0;
      M_SHORT: if (kn == {1'b0, nn} + 5'd1) conv_at_rise = 1'b1;
               else if (kn == {1'b0, nn} + 5'd2) conv_at_rise = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        acq <= '0;
    else if (!conv_o)                  acq <= '0;
    else if (acq != AW'(ACQ_CYC))      acq <= acq + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; tick <= '0; k <= '0; md <= '0; nn <= '0; sr <= '0;
      conv_o <= 1'b0; sclk_o <= 1'b0; done <= 1'b0; result <= '0; nvalid <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          md <= mode; nn <= n_req; conv_o <= 1'b1; state <= S_ACQ;
        end
        S_ACQ: if (acq == AW'(ACQ_CYC)) begin
          conv_o <= 1'b0; tick <= '0; sr <= '0; state <= S_GAP;
        end
        S_GAP, S_LO: if (half_end) begin
          tick <= '0;
          if (state == S_LO && k == k_last) begin
            state  <= S_IDLE;
            done   <= 1'b1;
            result <= md == M_SHORT ? sr << (4'(W) - nn) : sr;
            nvalid <= md == M_SHORT ? nn : 4'(W);
          end else begin
            state  <= S_HI;
            sclk_o <= 1'b1;
            k      <= kn;
            conv_o <= conv_at_rise;
            if (take) sr <= md == M_LSB ? {sdata_i, sr[W-1:1]} : {sr[W-2:0], sdata_i};
          end
        end else tick <= tick + 1'b1;
        S_HI: if (half_end) begin
          sclk_o <= 1'b0; tick <= '0; state <= S_LO;
        end else tick <= tick + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [TW:0] hi_len;
  logic [15:0] chi_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_len <= '0; chi_len <= '0;
    end else begin
      hi_len  <= sclk_o ? hi_len + 1'b1 : '0;
      chi_len <= !conv_o ? '0 : (&chi_len ? chi_len : chi_len + 1'b1);
    end

  assert_sclk_high_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> hi_len == (TW+1)'(HALF_CYC));
  assert_acq_before_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(conv_o) && !sclk_o) |-> chi_len >= 16'(ACQ_CYC));
  assert_conv_quiet_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(conv_o));
  assert_nvalid_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (nvalid >= 4'd1 && nvalid <= 4'd12));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_no_clock_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !sclk_o);
endmodule

// File: tb/test_adc_capture_ctrl.sv
module test_adc_capture_ctrl;
  localparam int SYS_NS = 4, HALF_DIV = 10, ACQ_NS = 350;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdata = 1'b0;
  logic [1:0] mode = '0;
  logic [3:0] nbits = '0;
  logic ready, done, conv, sclk;
  logic [11:0] result;
  logic [3:0] nvalid;

  always #2 clk = ~clk;

  adc_capture_ctrl #(.SYS_NS(SYS_NS), .HALF_DIV(HALF_DIV), .ACQ_NS(ACQ_NS)) i_adc_capture_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .nbits(nbits),
    .ready(ready), .done(done), .result(result), .nvalid(nvalid),
    .conv_o(conv), .sclk_o(sclk), .sdata_i(sdata));

  int ntests = 0, nfail = 0, half_c, acq_c;
  bit finished = 0;
  logic [11:0] m_val;
  logic [1:0] m_mode;
  int m_n, rises, rise_cnt, fall_cnt, hi_cnt, cc_hi, lat, acq_seen, lat_seen, hi_seen, per_seen, gap_seen;
  bit lat_on, bad_hi, bad_per, bad_gap, bad_q;
  logic psclk = 1'b0, pconv = 1'b0;
  logic conv_at [1:32];

  function automatic int cdiv(int a, int b); return (a + b - 1) / b; endfunction
  function automatic int exp_half();
    int h = HALF_DIV;
    if (h < cdiv(125, 2*SYS_NS)) h = cdiv(125, 2*SYS_NS);
    if (h < cdiv(50, SYS_NS)) h = cdiv(50, SYS_NS);
    if (h > 5000 / (2*SYS_NS)) h = 5000 / (2*SYS_NS);
    return h;
  endfunction
  function automatic int nclamp(logic [3:0] nb);
    return nb == 0 ? 1 : (nb > 10 ? 10 : int'(nb));
  endfunction
  function automatic logic bitfor(int k);
    if (k <= 1) return 1'b0;
    if (m_mode == 2'd3 && k >= m_n + 2) return 1'b1;
    if (k <= 13) return m_val[13 - k];
    if (m_mode == 2'd1 && k <= 24) return m_val[k - 13];
    return 1'b0;
  endfunction
  function automatic int exp_clocks(logic [1:0] md, int n);
    return md == 2'd1 ? 24 : (md == 2'd3 ? n + 2 : 13);
  endfunction
  function automatic logic exp_conv(logic [1:0] md, int n, int k);
    case (md)
      2'd0: return k >= 12;
      2'd1: return k == 12;
      2'd3: return k == n + 1;
      default: return 1'b0;
    endcase
  endfunction
  function automatic logic [11:0] exp_result(logic [1:0] md, int n, logic [11:0] v);
    return md == 2'd3 ? v & (12'hFFF << (12 - n)) : v;
  endfunction
  function automatic string rtag(logic [1:0] md);
    case (md) 2'd0: return "R5"; 2'd1: return "R7"; 2'd2: return "R6"; default: return "R8"; endcase
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    rise_cnt++; fall_cnt++;
    if (lat_on) lat++;
    if (sclk && psclk && conv != pconv) bad_q = 1;
    if (sclk && !psclk) begin
      rises++;
      if (rises <= 32) conv_at[rises] = conv;
      if (rises == 1) begin gap_seen = fall_cnt; if (fall_cnt != half_c) bad_gap = 1; end
      else if (rise_cnt != 2*half_c) begin bad_per = 1; per_seen = rise_cnt; end
      rise_cnt = 0;
    end
    if (sclk) hi_cnt++;
    else if (psclk) begin
      if (hi_cnt != half_c) begin bad_hi = 1; hi_seen = hi_cnt; end
      hi_cnt = 0;
    end
    if (!conv && pconv && !sclk) begin
      acq_seen = cc_hi; fall_cnt = 0;
      if (lat_on) begin lat_seen = lat; lat_on = 0; end
    end
    if (conv) cc_hi++; else cc_hi = 0;
    sdata = bitfor(rises + 1);
    psclk = sclk; pconv = conv;
  end

  task automatic run_frame(logic [1:0] md, logic [3:0] nb, logic [11:0] v, bit poke);
    int n = nclamp(nb), to = 0, badk = 0;
    while (!ready) @(negedge clk);
    m_val = v; m_mode = md; m_n = n; rises = 0; lat = 0; lat_on = 1;
    bad_hi = 0; bad_per = 0; bad_gap = 0; bad_q = 0; acq_seen = 0;
    for (int i = 1; i <= 32; i++) conv_at[i] = 1'b0;
    sdata = 1'b0;
    start = 1'b1; mode = md; nbits = nb;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1; mode = ~md; nbits = 4'd3;
      @(negedge clk); start = 1'b0;
    end
    while (!done && to < 5000) begin @(negedge clk); to++; end
    chk(done == 1'b1, "R9 done strobe seen", int'(done), 1);
    chk(result == exp_result(md, n, v), {rtag(md), " result"}, int'(result), int'(exp_result(md, n, v)));
    chk(nvalid == (md == 2'd3 ? n : 12), "R9/R8 nvalid", int'(nvalid), md == 2'd3 ? n : 12);
    chk(rises == exp_clocks(md, n), {rtag(md), " clock count"}, rises, exp_clocks(md, n));
    for (int k = 1; k <= exp_clocks(md, n); k++)
      if (badk == 0 && conv_at[k] != exp_conv(md, n, k)) badk = k;
    chk(badk == 0, {rtag(md), " convert level at first wrong clock"}, badk, 0);
    chk(conv == (md == 2'd0), {rtag(md), " convert after done"}, int'(conv), int'(md == 2'd0));
    chk(!bad_hi && !bad_per, "R2 clock phase width", bad_hi ? hi_seen : per_seen, bad_hi ? half_c : 2*half_c);
    chk(!bad_gap, "R3 hold to first clock", gap_seen, half_c);
    chk(acq_seen > acq_c, "R3 acquisition length", acq_seen, acq_c + 1);
    chk(!bad_q, "R4 convert quiet in high phase", int'(bad_q), 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    int r;
    logic [11:0] keep;
    void'($urandom(32'd2024));
    half_c = exp_half();
    acq_c = cdiv(ACQ_NS, SYS_NS);
    repeat (5) @(negedge clk);
    chk(conv == 0 && sclk == 0, "R1 lines low in reset", int'({conv, sclk}), 0);
    chk(ready == 1 && done == 0, "R1 ready/done in reset", int'({ready, done}), 2);
    chk(result == 0 && nvalid == 0, "R1 outputs zero in reset", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_frame(2'd2, 4'd0, 12'hA5C, 0);
    run_frame(2'd0, 4'd0, 12'hFFF, 0);
    chk(lat_seen >= acq_c, "R3 full acquisition after power saving", lat_seen, acq_c);
    run_frame(2'd0, 4'd0, 12'h000, 0);
    chk(lat_seen < acq_c - half_c, "R3 acquisition counted from convert rise", lat_seen, acq_c - half_c);
    run_frame(2'd1, 4'd0, 12'h801, 0);
    run_frame(2'd3, 4'd1, 12'hFFF, 0);
    run_frame(2'd3, 4'd10, 12'h3FF, 0);
    run_frame(2'd3, 4'd0, 12'h7FF, 0);
    run_frame(2'd3, 4'd15, 12'hC03, 0);
    run_frame(2'd1, 4'd0, 12'h5A3, 1);
    keep = result; r = rises;
    repeat (200) @(negedge clk);
    chk(rises == r && ready == 1, "R10 busy start ignored, no extra frame", rises, r);
    chk(result == keep, "R9 result held between frames", int'(result), int'(keep));

    for (int i = 0; i < 40; i++)
      run_frame(2'($urandom % 4), 4'($urandom % 16), 12'($urandom % 4096), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule